// File: doc/BRIEF.md
# SD Card Block Data Engine

This block carries block-structured data between a 32-bit word stream and the DAT lines of an SD or MMC card. The lines are either DAT0 alone (narrow mode) or all four lanes (wide mode). A command engine pulses `start` once a data-bearing command has gone out. With that pulse it supplies the transfer direction, a repeat count that is one less than the number of blocks, and a per-block bit count. That count covers the data bits plus fifteen bits for each active lane. A write also takes a turnaround gap and the status token the card is expected to return.

Each cycle of `clk` stands for one card clock. When the engine has to swap a word with the stream side, it holds `bus_run` low for that cycle. The card clock is stopped during that cycle, so the pause is invisible on the bus. Writes frame every block with a gap, a start bit, the data, a per-lane CRC16 and an end bit. The engine then takes the card's three-bit status token and waits out the busy signal on DAT0. Reads wait for the start bit, assemble words, and check each lane's CRC16. At the end, `done` pulses once with a CRC-OK flag for the direction used.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, `busy`, `bus_run`, `done`, `wready`, `rvalid` and `dat_oe` are all low.
- R2: A transfer moves `blk_rep`+1 blocks, then pulses `done` for exactly one cycle and returns to idle.
- R3: Data clocks per block are (`blk_bits` − 15×lanes)/lanes, with lanes = 4 when `wide` is 1 and 1 when it is 0. Words go out most significant bit first. In wide mode each clock carries bits [31:28] of the remaining word on DAT3..DAT0. In narrow mode only DAT0 is driven (`dat_oe` = 4'b0001).
- R4: A write block drives exactly `wr_gap` clocks of all active lanes high, then one start clock of all active lanes low, then the data, then 16 CRC clocks, then one end clock of all active lanes high. Lines are driven only in these phases of a write.
- R5: Each lane's CRC16 uses polynomial 0x1021 and seed 0 over that lane's own data bits, and is sent most significant bit first.
- R6: After a written block, the engine waits for a low start bit on DAT0 and takes three token bits, most significant first. It then skips one end bit. A token different from `tok_exp` clears `wr_crc_ok`. The expected card token for a good block is 3'b010.
- R7: After the token, the engine does not begin the next block until DAT0 is sampled high, and drives no line while DAT0 is low.
- R8: A read block starts at a low start bit on DAT0, followed by data and 16 CRC clocks per lane and one end bit. Words are presented in bus order. A CRC mismatch on any active lane clears `rd_crc_ok`.
- R9: With `rd_negedge` = 1, read lines are sampled on the falling edge of `clk`; with 0, on the rising edge.
- R10: `wready` and `rvalid` are asserted only in cycles with `bus_run` low. `rdata` stays stable while `rvalid` is high and `rready` is low.
- R11: At `done`, `wr_crc_ok` reports a write and `rd_crc_ok` a read. The flag of the unused direction is 0, and both hold until the next accepted start.
- R12: `start` and every configuration input are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card clock per cycle when `bus_run` is high |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| wr_mode | input | 1 | 1 = write to card, 0 = read from card |
| wide | input | 1 | 1 = four lanes, 0 = DAT0 only |
| blk_rep | input | 8 | Number of blocks minus one |
| blk_bits | input | 14 | Data bits per block plus 15 per active lane |
| wr_gap | input | 6 | Idle clocks before each written block |
| tok_exp | input | 3 | Expected card status token |
| rd_negedge | input | 1 | Sample card lines on the falling edge |
| wdata | input | 32 | Write word |
| wvalid | input | 1 | Write word available |
| wready | output | 1 | Write word taken this cycle |
| rdata | output | 32 | Read word |
| rvalid | output | 1 | Read word available |
| rready | input | 1 | Read word accepted |
| dat_i | input | 4 | DAT lines from card |
| dat_o | output | 4 | DAT lines to card |
| dat_oe | output | 4 | Per-lane output enable |
| bus_run | output | 1 | Card clock runs this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_crc_ok | output | 1 | All read blocks passed CRC |
| wr_crc_ok | output | 1 | All written blocks got the expected token |

## Verification
Writes are tried in narrow mode with two words per block, and in wide mode with three blocks and a write source that stalls. Each card-side decode of gap length, start bit, word bits and per-lane CRC separates lane mapping from bit order. Token tests pair a mismatching card token with a non-default programmed token and a zero gap, which tells the comparison apart from a fixed constant. Reads cover narrow and wide mode with receiver stalls, a single corrupted CRC bit on one lane of a later block, and falling-edge sampling. In that last case the bench flips the line after the falling edge, so rising-edge sampling would see garbage. A stray `start` with different settings is injected mid-transfer.

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer #(
  parameter int DW    = 32,
  parameter int REP_W = 8,
  parameter int LEN_W = 14,
  parameter int GAP_W = 6,
  parameter int TOK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_mode,
  input  logic             wide,
  input  logic [REP_W-1:0] blk_rep,
  input  logic [LEN_W-1:0] blk_bits,
  input  logic [GAP_W-1:0] wr_gap,
  input  logic [TOK_W-1:0] tok_exp,
  input  logic             rd_negedge,
  input  logic [DW-1:0]    wdata,
  input  logic             wvalid,
  output logic             wready,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  input  logic             rready,
  input  logic [3:0]       dat_i,
  output logic [3:0]       dat_o,
  output logic [3:0]       dat_oe,
  output logic             bus_run,
  output logic             busy,
  output logic             done,
  output logic             rd_crc_ok,
  output logic             wr_crc_ok
);
  localparam int WC_W  = $clog2(DW) + 1;
  localparam int CNT_W = (GAP_W > 5) ? GAP_W : 5;
  localparam logic [15:0] POLY = 16'h1021;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_GAP, S_START, S_DATA, S_PUSH, S_CRC,
    S_END, S_TWAIT, S_TOK, S_TEND, S_BUSY, S_RWAIT, S_DONE
  } st_t;

  st_t              st;
  logic             wr_q, wide_q, neg_q, first;
  logic [GAP_W-1:0] gap_q;
  logic [TOK_W-1:0] tok_q, tokv;
  logic [LEN_W-1:0] dclk_q, dcnt;
  logic [REP_W-1:0] brem;
  logic [WC_W-1:0]  wcnt;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    sh;
  logic [15:0]      crc [4];
  logic [3:0]       dat_n;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? POLY : 16'h0000);
  endfunction

  always_ff @(negedge clk) dat_n <= dat_i;

  logic [3:0]       lanes, dat_s, lbit;
  logic [WC_W-1:0]  wclk;
  logic [LEN_W-1:0] dbits, dclk_in;
  logic             res_bad;

  assign lanes   = wide_q ? 4'hF : 4'h1;
  assign dat_s   = neg_q ? dat_n : dat_i;
  assign lbit    = wr_q ? dat_o : dat_s;
  assign wclk    = wide_q ? WC_W'(DW / 4) : WC_W'(DW);
  assign dbits   = blk_bits - (wide ? LEN_W'(60) : LEN_W'(15));
  assign dclk_in = wide ? (dbits >> 2) : dbits;

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);
  assign wready  = (st == S_FETCH);
  assign rvalid  = (st == S_PUSH);
  assign rdata   = sh;
  assign bus_run = (st != S_IDLE) && (st != S_FETCH) && (st != S_PUSH) && (st != S_DONE);
  assign dat_oe  = (wr_q && (st == S_GAP || st == S_START || st == S_DATA ||
                             st == S_CRC || st == S_END)) ? lanes : 4'h0;
  assign rd_crc_ok = rd_q;
  assign wr_crc_ok = wo_q;

  logic rd_q, wo_q;

  always_comb begin
    res_bad = 1'b0;
    for (int l = 0; l < 4; l++)
      if (lanes[l] && crc[l] != 16'h0) res_bad = 1'b1;
  end

  always_comb begin
    dat_o = 4'hF;
    case (st)
      S_START: dat_o = ~lanes;
      S_DATA:  dat_o = wide_q ? sh[DW-1 -: 4] : {3'b111, sh[DW-1]};
      S_CRC:   for (int l = 0; l < 4; l++) dat_o[l] = crc[l][15] | ~lanes[l];
      default: dat_o = 4'hF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wr_q <= 1'b0; wide_q <= 1'b0; neg_q <= 1'b0; first <= 1'b0;
      gap_q <= '0; tok_q <= '0; tokv <= '0; dclk_q <= '0; dcnt <= '0;
      brem <= '0; wcnt <= '0; cnt <= '0; sh <= '0; rd_q <= 1'b0; wo_q <= 1'b0;
      for (int l = 0; l < 4; l++) crc[l] <= 16'h0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wr_q <= wr_mode; wide_q <= wide; neg_q <= rd_negedge;
          gap_q <= wr_gap; tok_q <= tok_exp; dclk_q <= dclk_in;
          brem <= blk_rep; first <= 1'b1;
          rd_q <= ~wr_mode; wo_q <= wr_mode;
          st <= wr_mode ? S_FETCH : S_RWAIT;
        end
        S_FETCH: if (wvalid) begin
          sh <= wdata; wcnt <= wclk;
          if (first) begin
            first <= 1'b0;
            if (gap_q != '0) begin st <= S_GAP; cnt <= CNT_W'(gap_q); end
            else st <= S_START;
          end else st <= S_DATA;
        end
        S_GAP: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_START;
        end
        S_START: begin
          dcnt <= dclk_q; st <= S_DATA;
          for (int l = 0; l < 4; l++) crc[l] <= 16'h0;
        end
        S_RWAIT: if (!dat_s[0]) begin
          dcnt <= dclk_q; wcnt <= wclk; st <= S_DATA;
          for (int l = 0; l < 4; l++) crc[l] <= 16'h0;
        end
        S_DATA: begin
          for (int l = 0; l < 4; l++) crc[l] <= crc_step(crc[l], lbit[l]);
          if (wr_q) sh <= wide_q ? {sh[DW-5:0], 4'hF} : {sh[DW-2:0], 1'b1};
          else      sh <= wide_q ? {sh[DW-5:0], dat_s} : {sh[DW-2:0], dat_s[0]};
          dcnt <= dcnt - 1'b1;
          wcnt <= wcnt - 1'b1;
          if (wcnt == WC_W'(1)) begin
            if (!wr_q) st <= S_PUSH;
            else if (dcnt == LEN_W'(1)) begin st <= S_CRC; cnt <= CNT_W'(16); end
            else st <= S_FETCH;
          end
        end
        S_PUSH: if (rready) begin
          wcnt <= wclk;
          if (dcnt == '0) begin st <= S_CRC; cnt <= CNT_W'(16); end
          else st <= S_DATA;
        end
        S_CRC: begin
          for (int l = 0; l < 4; l++)
            crc[l] <= wr_q ? {crc[l][14:0], 1'b0} : crc_step(crc[l], dat_s[l]);
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_END;
        end
        S_END: if (wr_q) st <= S_TWAIT;
        else begin
          if (res_bad) rd_q <= 1'b0;
          if (brem == '0) st <= S_DONE;
          else begin brem <= brem - 1'b1; st <= S_RWAIT; end
        end
        S_TWAIT: if (!dat_s[0]) begin st <= S_TOK; cnt <= CNT_W'(TOK_W); end
        S_TOK: begin
          tokv <= {tokv[TOK_W-2:0], dat_s[0]};
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_TEND;
        end
        S_TEND: begin
          if (tokv != tok_q) wo_q <= 1'b0;
          st <= S_BUSY;
        end
        S_BUSY: if (dat_s[0]) begin
          if (brem == '0) st <= S_DONE;
          else begin brem <= brem - 1'b1; first <= 1'b1; st <= S_FETCH; end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hs_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wready || rvalid) |-> !bus_run);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_lane_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dat_oe) |-> (dat_oe == 4'hF || dat_oe == 4'h1));
  p_drive_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dat_oe) |-> (busy && bus_run));
  p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(rd_crc_ok && wr_crc_ok));
endmodule

// File: tb/sd_blk_xfer_tb.sv
`timescale 1ns/1ps
module sd_blk_xfer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wr_mode = 0, wide = 0, rd_negedge = 0, wvalid = 0, rready = 0;
  logic [7:0] blk_rep = 0;
  logic [13:0] blk_bits = 0;
  logic [5:0] wr_gap = 0;
  logic [2:0] tok_exp = 3'b010;
  logic [31:0] wdata = 0, rdata;
  logic [3:0] dat_i = 4'hF, dat_o, dat_oe;
  logic wready, rvalid, bus_run, busy, done, rd_crc_ok, wr_crc_ok;

  sd_blk_xfer u_dut (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, dn = 0;
  bit f_rd, f_wr, src_stall = 0, rd_stall = 0, over = 0;
  logic [31:0] srcq[$], expq[$], rdq[$];
  logic [3:0] ob_o, ob_oe;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cstep(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0);
  endfunction

  // write source
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    wvalid = (srcq.size() > 0) && !(src_stall && (cyc % 3 == 0));
    wdata  = (srcq.size() > 0) ? srcq[0] : 32'h0;
    if (wvalid && wready) void'(srcq.pop_front());
  end

  // read monitor / scoreboard
  initial begin
    logic [31:0] held; bit was_stall = 0;
    forever begin
      @(posedge clk); #2;
      if (was_stall && rvalid) chk(rdata == held, "R10 rdata stable", rdata, held);
      rready = !(rd_stall && (cyc % 2 == 0));
      was_stall = rvalid && !rready;
      held = rdata;
      if (rvalid && rready) begin
        logic [31:0] e;
        chk(bus_run == 1'b0, "R10 stopped on handshake", bus_run, 0);
        e = (expq.size() > 0) ? expq.pop_front() : 32'hDEADBEEF;
        chk(rdata == e, "R8 read word", rdata, e);
      end
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (done) begin dn++; f_rd = rd_crc_ok; f_wr = wr_crc_ok; end
  end

  task automatic obs();
    do begin @(posedge clk); #1; end while (!bus_run);
    ob_o = dat_o; ob_oe = dat_oe;
  endtask

  task automatic put(input logic [3:0] v, input bit gl);
    bit r;
    do begin
      @(posedge clk); #1; dat_i = v; r = bus_run;
      if (gl) begin @(negedge clk); #1; dat_i = ~v; end
    end while (!r);
  endtask

  task automatic go(input bit wr, input bit wd, input int nblk, input int bits,
                    input int gap, input logic [2:0] tok, input bit neg);
    @(posedge clk); #1;
    wr_mode = wr; wide = wd; blk_rep = 8'(nblk - 1); blk_bits = 14'(bits);
    wr_gap = 6'(gap); tok_exp = tok; rd_negedge = neg; start = 1;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic card_wr(input int nblk, input bit wd, input int dclk, input int gap,
                         input logic [2:0] tok, input int bz);
    logic [3:0] ln; int wclk;
    ln = wd ? 4'hF : 4'h1; wclk = wd ? 8 : 32;
    for (int b = 0; b < nblk; b++) begin
      logic [15:0] cr [4]; logic [15:0] rx [4]; logic [31:0] w; int g, k;
      g = 0;
      forever begin
        obs();
        if (ob_oe[0] && ob_o[0] == 1'b0) break;
        if (ob_oe == ln && (ob_o & ln) == ln) g++;
      end
      chk(g == gap, "R4 gap length", g, gap);
      chk((ob_o & ln) == 0 && ob_oe == ln, "R4 start bit", {ob_oe, ob_o}, {ln, 4'h0});
      for (int l = 0; l < 4; l++) begin cr[l] = 0; rx[l] = 0; end
      w = 0; k = 0;
      for (int i = 0; i < dclk; i++) begin
        obs();
        if (wd) w = {w[27:0], ob_o}; else w = {w[30:0], ob_o[0]};
        for (int l = 0; l < 4; l++) if (ln[l]) cr[l] = cstep(cr[l], ob_o[l]);
        k++;
        if (k == wclk) begin
          logic [31:0] e;
          e = (expq.size() > 0) ? expq.pop_front() : 32'hDEADBEEF;
          chk(w == e, "R3 write word", w, e);
          k = 0;
        end
      end
      for (int i = 0; i < 16; i++) begin
        obs();
        for (int l = 0; l < 4; l++) rx[l] = {rx[l][14:0], ob_o[l]};
      end
      for (int l = 0; l < 4; l++)
        if (ln[l]) chk(rx[l] == cr[l], "R5 lane CRC16", rx[l], cr[l]);
      obs();
      chk((ob_o & ln) == ln && ob_oe == ln, "R4 end bit", {ob_oe, ob_o}, {ln, ln});
      put(4'hF, 0); put(4'hE, 0);
      for (int i = 2; i >= 0; i--) put({3'b111, tok[i]}, 0);
      put(4'hF, 0);
      for (int i = 0; i < bz; i++) begin
        put(4'hE, 0);
        chk(dat_oe == 4'h0, "R7 no drive while card busy", dat_oe, 0);
      end
      put(4'hF, 0);
    end
  endtask

  task automatic card_rd(input int nblk, input bit wd, input int wpb, input int badblk,
                         input int badlane, input bit gl);
    logic [3:0] ln; int wclk;
    ln = wd ? 4'hF : 4'h1; wclk = wd ? 8 : 32;
    for (int b = 0; b < nblk; b++) begin
      logic [15:0] cr [4]; logic [31:0] w; logic [3:0] v;
      put(4'hF, gl); put(4'hF, gl); put(wd ? 4'h0 : 4'hE, gl);
      for (int l = 0; l < 4; l++) cr[l] = 0;
      for (int j = 0; j < wpb; j++) begin
        w = rdq.pop_front();
        for (int i = 0; i < wclk; i++) begin
          if (wd) begin v = w[31:28]; w = w << 4; end
          else begin v = {3'b111, w[31]}; w = w << 1; end
          for (int l = 0; l < 4; l++) if (ln[l]) cr[l] = cstep(cr[l], v[l]);
          put(v, gl);
        end
      end
      for (int i = 0; i < 16; i++) begin
        v = 4'hF;
        for (int l = 0; l < 4; l++) if (ln[l]) v[l] = cr[l][15-i];
        if (b == badblk && i == 15) v[badlane] = ~v[badlane];
        put(v, gl);
      end
      put(4'hF, gl);
    end
    dat_i = 4'hF;
  endtask

  task automatic load(input bit wr, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = seed ^ (32'h9E3779B9 * (i + 1)) ^ (i << 7);
      if (wr) srcq.push_back(w); else rdq.push_back(w);
      expq.push_back(w);
    end
  endtask

  task automatic finish_xfer(input string tag, input bit wr, input bit ok_exp, input int dn0);
    do begin @(posedge clk); #1; end while (busy);
    chk(dn == dn0 + 1, {tag, " R2 single done"}, dn, dn0 + 1);
    chk(expq.size() == 0, {tag, " R2 all blocks moved"}, expq.size(), 0);
    if (wr) begin
      chk(f_wr == ok_exp, {tag, " R6 write status"}, f_wr, ok_exp);
      chk(f_rd == 1'b0, {tag, " R11 read flag clear"}, f_rd, 0);
    end else begin
      chk(f_rd == ok_exp, {tag, " R8 read status"}, f_rd, ok_exp);
      chk(f_wr == 1'b0, {tag, " R11 write flag clear"}, f_wr, 0);
    end
    expq.delete(); srcq.delete(); rdq.delete();
  endtask

  task automatic summary();
    if (!over) begin
      over = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int d0;
    repeat (3) @(posedge clk); #1;
    chk({busy, bus_run, done, wready, rvalid, dat_oe} == 0, "R1 reset outputs",
        {busy, bus_run, done, wready, rvalid, dat_oe}, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // T1: narrow write, 1 block of 2 words
    load(1, 2, 32'hA5A50F0F); d0 = dn;
    fork go(1, 0, 1, 64 + 15, 2, 3'b010, 0); card_wr(1, 0, 64, 2, 3'b010, 3); join
    finish_xfer("T1", 1, 1, d0);

    // T2: wide write, 3 blocks of 4 words, source stalls, stray start (R12)
    load(1, 12, 32'h12345678); d0 = dn; src_stall = 1;
    fork
      go(1, 1, 3, 128 + 60, 5, 3'b010, 0);
      card_wr(3, 1, 32, 5, 3'b010, 4);
      begin repeat (40) @(posedge clk); #1; wr_mode = 0; wide = 0; blk_rep = 8'd9; start = 1;
            @(posedge clk); #1; start = 0; end
    join
    src_stall = 0;
    finish_xfer("T2 R12", 1, 1, d0);
    repeat (10) @(posedge clk); #1;
    chk(busy == 0 && dn == d0 + 1, "R12 stray start ignored", busy, 0);

    // T3: wide write, card returns bad token
    load(1, 1, 32'hCAFEF00D); d0 = dn;
    fork go(1, 1, 1, 32 + 60, 1, 3'b010, 0); card_wr(1, 1, 8, 1, 3'b101, 2); join
    finish_xfer("T3", 1, 0, d0);

    // T4: narrow write, programmed token 101, no gap
    load(1, 1, 32'h0BADC0DE); d0 = dn;
    fork go(1, 0, 1, 32 + 15, 0, 3'b101, 0); card_wr(1, 0, 32, 0, 3'b101, 0); join
    finish_xfer("T4", 1, 1, d0);

    // T5: narrow read, 2 blocks of 1 word
    load(0, 2, 32'h5EED0001); d0 = dn;
    fork go(0, 0, 2, 32 + 15, 0, 3'b010, 0); card_rd(2, 0, 1, -1, 0, 0); join
    finish_xfer("T5", 0, 1, d0);

    // T6: wide read, 2 blocks of 2 words, receiver stalls
    load(0, 4, 32'h77AA33CC); d0 = dn; rd_stall = 1;
    fork go(0, 1, 2, 64 + 60, 0, 3'b010, 0); card_rd(2, 1, 2, -1, 0, 0); join
    rd_stall = 0;
    finish_xfer("T6", 0, 1, d0);

    // T7: wide read, CRC bit flipped on lane 2 of block 1
    load(0, 2, 32'hF00DFACE); d0 = dn;
    fork go(0, 1, 2, 32 + 60, 0, 3'b010, 0); card_rd(2, 1, 1, 1, 2, 0); join
    finish_xfer("T7", 0, 0, d0);

    // T8: wide read on falling edge, lines glitch after falling edge (R9)
    load(0, 2, 32'h31415926); d0 = dn;
    fork go(0, 1, 1, 64 + 60, 0, 3'b010, 1); card_rd(1, 1, 2, -1, 0, 1); join
    finish_xfer("T8 R9", 0, 1, d0);

    repeat (5) @(posedge clk);
    summary();
  end
endmodule